// File: doc/BRIEF.md
# Duplicated Montgomery Ladder Point Multiplier with Fault Detection

This block multiplies a point on a binary-field elliptic curve by a scalar. It uses the Montgomery ladder in projective x-only coordinates. The caller supplies a scalar, the affine x coordinate of the base point and the curve constant b, then pulses `start`. The block forms the projective starting values and walks the scalar from the bit just below its most significant set bit down to bit 0. For every bit it performs one point addition and one point doubling, whatever the bit's value. When it finishes it presents the projective pair (X1, Z1), which holds the multiple, and the pair (X2, Z2), which holds the next multiple. Affine conversion and field inversion are left to the surrounding design.

Two lanes hold the register file and the two bit-serial field multipliers, and one controller steps both lanes in lockstep. The entry stage and the ladder loop each end with a write-back. At each of these two write-backs the two lanes exchange every even-numbered byte of their four coordinates, so a fault that strikes one lane ends up spread across both. The compare cycle after the ladder checks the lanes against each other word by word. If any word differs, the block raises `fault_o` and forces all four coordinates to zero, so no partial or corrupted result leaves the block.

Top module: `mont_dual_ladder`

## Requirements
- R1: The block samples `start` only while idle. On such a start it latches the scalar, the base x and the curve constant. Changes to those inputs after that edge have no effect on the running operation.
- R2: `done_o` is high for exactly one cycle per operation. `fault_o` is valid in that same cycle and changes value only in a cycle where `done_o` is high.
- R3: On a fault-free run the outputs equal the ladder result, computed as follows. All field arithmetic is modulo the parameter polynomial; the default is x^163 + x^7 + x^6 + x^3 + 1, and the bench uses x^7 + x + 1.
  - Start values: X1 = x, Z1 = 1, X2 = x^4 + b, Z2 = x^2.
  - For each bit, from just below the top set bit down to bit 0: a set bit writes the sum to (X1,Z1) and the double of (X2,Z2) to (X2,Z2); a clear bit does the mirror image.
  - Sum: Z = (X1·Z2 + X2·Z1)^2 and X = x·Z + (X1·Z2)·(X2·Z1).
  - Double of (X,Z): X' = X^4 + b·Z^4 and Z' = X^2·Z^2.
- R4: A scalar of 0 or 1 runs no ladder iterations and returns the start values of R3.
- R5: With t the index of the scalar's top set bit (t = 0 for a scalar of 0 or 1), `done_o` first reads high after the ((2 + 6t)·(M + 2) + 1)-th rising edge that follows the edge sampling `start`. Each field product takes a fixed M + 2 cycles.
- R6: A `start` pulse while an operation is running is ignored. The running operation's result and completion time stay unchanged.
- R7: If the two lanes disagree in any coordinate at the compare, `fault_o` is 1 and all four coordinate outputs are zero.
- R8: If the lanes agree, `fault_o` is 0 in the `done_o` cycle, even when the previous operation faulted.
- R9: The coordinate outputs and `fault_o` hold their values in every cycle where `done_o` is low.
- R10: After reset, all coordinate outputs, `done_o` and `fault_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| scalar_i | input | M | Scalar multiplier |
| base_x_i | input | M | Affine x coordinate of the base point |
| curve_b_i | input | M | Curve constant b |
| x1_o | output | M | Result X1 (projective) |
| z1_o | output | M | Result Z1 (projective) |
| x2_o | output | M | Result X2 (projective) |
| z2_o | output | M | Result Z2 (projective) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Lane mismatch detected at the compare |

## Verification
The hardest case to reach is a disagreement between the two lanes, because a correct design keeps them identical and no port can desynchronise them. The bench gets there by forcing the product output of the first multiplier in the second lane to all ones. It holds the force over a window covering one whole ladder bit, so several write-backs in that lane go wrong. It then checks that the fault flag rises, that all four coordinates come out as zero, and that a clean run straight afterwards clears the flag. Every other case comes from an exhaustive sweep of a 7-bit field, with the expected values and the completion latency computed arithmetically.

// File: rtl/mont_pkg.sv
package mont_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctl_state_e;

    typedef enum logic [3:0] {
        OP_XP, OP_ZP, OP_XQ, OP_ZQ,
        OP_T0, OP_T1, OP_T2, OP_T3,
        OP_SUM, OP_X, OP_B, OP_ONE
    } opnd_e;

    typedef enum logic [3:0] {
        DS_NONE, DS_XP, DS_ZP, DS_XQ, DS_ZQ,
        DS_T0, DS_T1, DS_T2, DS_T3
    } dest_e;

    typedef enum logic [1:0] {AD_NONE, AD_T0, AD_T2, AD_B} addend_e;

    typedef struct packed {
        opnd_e   a0;
        opnd_e   b0;
        dest_e   d0;
        addend_e c0;
        opnd_e   a1;
        opnd_e   b1;
        dest_e   d1;
        addend_e c1;
    } ucode_t;

    // Steps 0..1 form the entry stage; steps 2..7 form one ladder bit.
    // P is the pair receiving the sum, Q the pair being doubled.
    function automatic ucode_t mont_ucode(logic [2:0] s);
        ucode_t u;
        case (s)
            3'd0:    u = '{OP_X,   OP_X,   DS_ZQ, AD_NONE, OP_ONE, OP_ONE, DS_NONE, AD_NONE};
            3'd1:    u = '{OP_ZQ,  OP_ZQ,  DS_XQ, AD_B,    OP_ONE, OP_ONE, DS_NONE, AD_NONE};
            3'd2:    u = '{OP_XP,  OP_ZQ,  DS_T0, AD_NONE, OP_XQ,  OP_ZP,  DS_T1,   AD_NONE};
            3'd3:    u = '{OP_XQ,  OP_XQ,  DS_T2, AD_NONE, OP_ZQ,  OP_ZQ,  DS_T3,   AD_NONE};
            3'd4:    u = '{OP_SUM, OP_SUM, DS_ZP, AD_NONE, OP_T0,  OP_T1,  DS_T0,   AD_NONE};
            3'd5:    u = '{OP_X,   OP_ZP,  DS_XP, AD_T0,   OP_T2,  OP_T3,  DS_ZQ,   AD_NONE};
            3'd6:    u = '{OP_T2,  OP_T2,  DS_T2, AD_NONE, OP_T3,  OP_T3,  DS_T3,   AD_NONE};
            default: u = '{OP_B,   OP_T3,  DS_XQ, AD_T2,   OP_ONE, OP_ONE, DS_NONE, AD_NONE};
        endcase
        return u;
    endfunction

endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
    parameter int          M        = 163,
    parameter logic [M-1:0] POLY_LOW = M'('hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] p_o
);
    typedef struct packed {
        logic [M-1:0] a;
        logic [M-1:0] b;
        logic [M-1:0] acc;
    } mul_t;

    mul_t mul_d, mul_q;

    // MSB-first shift-and-add; M steps after a load give a*b mod poly.
    always_comb begin
        mul_d = mul_q;
        if (load_i) begin
            mul_d.a   = a_i;
            mul_d.b   = b_i;
            mul_d.acc = '0;
        end else if (step_i) begin
            mul_d.acc = {mul_q.acc[M-2:0], 1'b0}
                      ^ (mul_q.acc[M-1] ? POLY_LOW : '0)
                      ^ (mul_q.b[M-1]   ? mul_q.a  : '0);
            mul_d.b   = {mul_q.b[M-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_q <= '0;
        else        mul_q <= mul_d;
    end

    assign p_o = mul_q.acc;

    assert_load_not_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !step_i);

endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
    import mont_pkg::*;
#(
    parameter int M = 163
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] scalar_i,
    output logic         init_o,
    output logic         ki_o,
    output logic [2:0]   step_o,
    output logic         mul_load_o,
    output logic         mul_step_o,
    output logic         wb_o,
    output logic         swap_o,
    output logic         fin_o
);
    localparam int IW = $clog2(M);
    localparam int CW = $clog2(M + 2);
    localparam logic [CW-1:0] WB_CNT = CW'(M + 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [M-1:0]  k;
        logic [IW-1:0] r;
        logic [2:0]    step;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [IW-1:0] msb;
    logic [IW-1:0] bit_idx;

    always_comb begin
        msb = '0;
        for (int i = 0; i < M; i++)
            if (scalar_i[i]) msb = IW'(i);
    end

    assign bit_idx    = ctl_q.r - 1'b1;
    assign step_o     = ctl_q.step;
    assign ki_o       = (ctl_q.step < 3'd2) ? 1'b1 : ctl_q.k[bit_idx];
    assign mul_load_o = (ctl_q.st == ST_RUN) && (ctl_q.cnt == '0);
    assign mul_step_o = (ctl_q.st == ST_RUN) && (ctl_q.cnt != '0) && (ctl_q.cnt != WB_CNT);
    assign wb_o       = (ctl_q.st == ST_RUN) && (ctl_q.cnt == WB_CNT);

    always_comb begin
        ctl_d  = ctl_q;
        init_o = 1'b0;
        swap_o = 1'b0;
        fin_o  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: if (start) begin
                init_o     = 1'b1;
                ctl_d.k    = scalar_i;
                ctl_d.r    = msb;
                ctl_d.step = 3'd0;
                ctl_d.cnt  = '0;
                ctl_d.st   = ST_RUN;
            end
            ST_RUN: begin
                if (wb_o) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.step == 3'd1) begin
                        swap_o = 1'b1;
                        if (ctl_q.r == '0) ctl_d.st   = ST_FIN;
                        else               ctl_d.step = 3'd2;
                    end else if (ctl_q.step == 3'd7) begin
                        ctl_d.r = ctl_q.r - 1'b1;
                        if (ctl_q.r == IW'(1)) begin
                            swap_o   = 1'b1;
                            ctl_d.st = ST_FIN;
                        end else begin
                            ctl_d.step = 3'd2;
                        end
                    end else begin
                        ctl_d.step = ctl_q.step + 3'd1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                fin_o    = 1'b1;
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE && start) |=> $stable(ctl_q.k));

    assert_fin_follows_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FIN) |-> $past(wb_o));

endmodule

// File: rtl/mont_lane.sv
module mont_lane
    import mont_pkg::*;
#(
    parameter int           M        = 163,
    parameter logic [M-1:0] POLY_LOW = M'('hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic [M-1:0] x_i,
    input  logic [M-1:0] b_i,
    input  logic         ki_i,
    input  logic [2:0]   step_i,
    input  logic         mul_load_i,
    input  logic         mul_step_i,
    input  logic         wb_i,
    input  logic         swap_i,
    input  logic [M-1:0] peer_x1_i,
    input  logic [M-1:0] peer_z1_i,
    input  logic [M-1:0] peer_x2_i,
    input  logic [M-1:0] peer_z2_i,
    output logic [M-1:0] nx_x1_o,
    output logic [M-1:0] nx_z1_o,
    output logic [M-1:0] nx_x2_o,
    output logic [M-1:0] nx_z2_o,
    output logic [M-1:0] x1_o,
    output logic [M-1:0] z1_o,
    output logic [M-1:0] x2_o,
    output logic [M-1:0] z2_o
);
    typedef struct packed {
        logic [M-1:0] x, b, x1, z1, x2, z2, t0, t1, t2, t3;
    } lane_t;

    function automatic logic [M-1:0] even_mask();
        logic [M-1:0] m;
        for (int i = 0; i < M; i++) m[i] = ((i / 8) % 2) == 0;
        return m;
    endfunction

    localparam logic [M-1:0] EVEN = even_mask();

    function automatic logic [M-1:0] pick(opnd_e c, lane_t r, logic ki);
        case (c)
            OP_XP:   return ki ? r.x1 : r.x2;
            OP_ZP:   return ki ? r.z1 : r.z2;
            OP_XQ:   return ki ? r.x2 : r.x1;
            OP_ZQ:   return ki ? r.z2 : r.z1;
            OP_T0:   return r.t0;
            OP_T1:   return r.t1;
            OP_T2:   return r.t2;
            OP_T3:   return r.t3;
            OP_SUM:  return r.t0 ^ r.t1;
            OP_X:    return r.x;
            OP_B:    return r.b;
            OP_ONE:  return M'(1);
            default: return '0;
        endcase
    endfunction

    function automatic logic [M-1:0] addend(addend_e c, lane_t r);
        case (c)
            AD_T0:   return r.t0;
            AD_T2:   return r.t2;
            AD_B:    return r.b;
            default: return '0;
        endcase
    endfunction

    function automatic lane_t put(lane_t r, dest_e d, logic ki, logic [M-1:0] v);
        lane_t o = r;
        case (d)
            DS_XP:   if (ki) o.x1 = v; else o.x2 = v;
            DS_ZP:   if (ki) o.z1 = v; else o.z2 = v;
            DS_XQ:   if (ki) o.x2 = v; else o.x1 = v;
            DS_ZQ:   if (ki) o.z2 = v; else o.z1 = v;
            DS_T0:   o.t0 = v;
            DS_T1:   o.t1 = v;
            DS_T2:   o.t2 = v;
            DS_T3:   o.t3 = v;
            default: ;
        endcase
        return o;
    endfunction

    lane_t  lane_d, lane_q, nxt;
    ucode_t uc;
    logic [M-1:0] prod0, prod1;

    assign uc = mont_ucode(step_i);

    gf_mul #(.M(M), .POLY_LOW(POLY_LOW)) u_mul0 (
        .clk(clk), .rst_n(rst_n), .load_i(mul_load_i), .step_i(mul_step_i),
        .a_i(pick(uc.a0, lane_q, ki_i)), .b_i(pick(uc.b0, lane_q, ki_i)), .p_o(prod0)
    );
    gf_mul #(.M(M), .POLY_LOW(POLY_LOW)) u_mul1 (
        .clk(clk), .rst_n(rst_n), .load_i(mul_load_i), .step_i(mul_step_i),
        .a_i(pick(uc.a1, lane_q, ki_i)), .b_i(pick(uc.b1, lane_q, ki_i)), .p_o(prod1)
    );

    always_comb begin
        nxt = lane_q;
        if (init_i) begin
            nxt    = '0;
            nxt.x  = x_i;
            nxt.b  = b_i;
            nxt.x1 = x_i;
            nxt.z1 = M'(1);
        end else if (wb_i) begin
            nxt = put(nxt, uc.d0, ki_i, prod0 ^ addend(uc.c0, lane_q));
            nxt = put(nxt, uc.d1, ki_i, prod1 ^ addend(uc.c1, lane_q));
        end
        lane_d = nxt;
        if (swap_i) begin
            lane_d.x1 = (nxt.x1 & ~EVEN) | (peer_x1_i & EVEN);
            lane_d.z1 = (nxt.z1 & ~EVEN) | (peer_z1_i & EVEN);
            lane_d.x2 = (nxt.x2 & ~EVEN) | (peer_x2_i & EVEN);
            lane_d.z2 = (nxt.z2 & ~EVEN) | (peer_z2_i & EVEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign nx_x1_o = nxt.x1;
    assign nx_z1_o = nxt.z1;
    assign nx_x2_o = nxt.x2;
    assign nx_z2_o = nxt.z2;
    assign x1_o    = lane_q.x1;
    assign z1_o    = lane_q.z1;
    assign x2_o    = lane_q.x2;
    assign z2_o    = lane_q.z2;

endmodule

// File: rtl/mont_dual_ladder.sv
module mont_dual_ladder
    import mont_pkg::*;
#(
    parameter int           M        = 163,
    parameter logic [M-1:0] POLY_LOW = M'('hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] scalar_i,
    input  logic [M-1:0] base_x_i,
    input  logic [M-1:0] curve_b_i,
    output logic [M-1:0] x1_o,
    output logic [M-1:0] z1_o,
    output logic [M-1:0] x2_o,
    output logic [M-1:0] z2_o,
    output logic         done_o,
    output logic         fault_o
);
    logic       init, ki, mul_load, mul_step, wb, swap, fin;
    logic [2:0] step;
    logic [M-1:0] a_nx1, a_nz1, a_nx2, a_nz2, a_x1, a_z1, a_x2, a_z2;
    logic [M-1:0] b_nx1, b_nz1, b_nx2, b_nz2, b_x1, b_z1, b_x2, b_z2;

    typedef struct packed {
        logic [M-1:0] x1, z1, x2, z2;
        logic         done;
        logic         fault;
    } out_t;

    out_t out_d, out_q;
    logic mismatch;

    mont_ctrl #(.M(M)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar_i(scalar_i),
        .init_o(init), .ki_o(ki), .step_o(step), .mul_load_o(mul_load),
        .mul_step_o(mul_step), .wb_o(wb), .swap_o(swap), .fin_o(fin)
    );

    mont_lane #(.M(M), .POLY_LOW(POLY_LOW)) u_lane_a (
        .clk(clk), .rst_n(rst_n), .init_i(init), .x_i(base_x_i), .b_i(curve_b_i),
        .ki_i(ki), .step_i(step), .mul_load_i(mul_load), .mul_step_i(mul_step),
        .wb_i(wb), .swap_i(swap),
        .peer_x1_i(b_nx1), .peer_z1_i(b_nz1), .peer_x2_i(b_nx2), .peer_z2_i(b_nz2),
        .nx_x1_o(a_nx1), .nx_z1_o(a_nz1), .nx_x2_o(a_nx2), .nx_z2_o(a_nz2),
        .x1_o(a_x1), .z1_o(a_z1), .x2_o(a_x2), .z2_o(a_z2)
    );

    mont_lane #(.M(M), .POLY_LOW(POLY_LOW)) u_lane_b (
        .clk(clk), .rst_n(rst_n), .init_i(init), .x_i(base_x_i), .b_i(curve_b_i),
        .ki_i(ki), .step_i(step), .mul_load_i(mul_load), .mul_step_i(mul_step),
        .wb_i(wb), .swap_i(swap),
        .peer_x1_i(a_nx1), .peer_z1_i(a_nz1), .peer_x2_i(a_nx2), .peer_z2_i(a_nz2),
        .nx_x1_o(b_nx1), .nx_z1_o(b_nz1), .nx_x2_o(b_nx2), .nx_z2_o(b_nz2),
        .x1_o(b_x1), .z1_o(b_z1), .x2_o(b_x2), .z2_o(b_z2)
    );

    assign mismatch = (a_x1 != b_x1) || (a_z1 != b_z1) || (a_x2 != b_x2) || (a_z2 != b_z2);

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (fin) begin
            out_d.done  = 1'b1;
            out_d.fault = mismatch;
            out_d.x1    = mismatch ? '0 : a_x1;
            out_d.z1    = mismatch ? '0 : a_z1;
            out_d.x2    = mismatch ? '0 : a_x2;
            out_d.z2    = mismatch ? '0 : a_z2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign x1_o    = out_q.x1;
    assign z1_o    = out_q.z1;
    assign x2_o    = out_q.x2;
    assign z2_o    = out_q.z2;
    assign done_o  = out_q.done;
    assign fault_o = out_q.fault;

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fault_moves_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_o) |-> done_o);

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(x1_o) && $stable(z1_o) && $stable(x2_o) && $stable(z2_o)));

    assert_fault_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (x1_o == '0 && z1_o == '0 && x2_o == '0 && z2_o == '0));

endmodule

// File: tb/tb_mont_dual_ladder.sv
module tb_mont_dual_ladder;
    localparam int M = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [M-1:0] scalar = '0, bx = '0, cb = '0;
    logic [M-1:0] x1, z1, x2, z2;
    logic done, fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mont_dual_ladder #(.M(M), .POLY_LOW(7'h03)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar_i(scalar),
        .base_x_i(bx), .curve_b_i(cb), .x1_o(x1), .z1_o(z1), .x2_o(x2), .z2_o(z2),
        .done_o(done), .fault_o(fault)
    );

    function automatic logic [6:0] fm(logic [6:0] a, logic [6:0] b);
        logic [6:0] acc;
        acc = '0;
        for (int i = 6; i >= 0; i--) begin
            acc = {acc[5:0], 1'b0} ^ (acc[6] ? 7'h03 : 7'h00);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic int top_bit(logic [6:0] k);
        int t;
        t = 0;
        for (int i = 0; i < 7; i++) if (k[i]) t = i;
        return t;
    endfunction

    function automatic logic [27:0] ref_ladder(logic [6:0] k, logic [6:0] x, logic [6:0] b);
        logic [6:0] X1, Z1, X2, Z2, p, q, sz, sx, dx, dz;
        X1 = x; Z1 = 7'd1;
        Z2 = fm(x, x);
        X2 = fm(Z2, Z2) ^ b;
        for (int i = top_bit(k) - 1; i >= 0; i--) begin
            p  = fm(X1, Z2);
            q  = fm(X2, Z1);
            sz = fm(p ^ q, p ^ q);
            sx = fm(x, sz) ^ fm(p, q);
            if (k[i]) begin
                dx = fm(fm(X2, X2), fm(X2, X2)) ^ fm(b, fm(fm(Z2, Z2), fm(Z2, Z2)));
                dz = fm(fm(X2, X2), fm(Z2, Z2));
                X1 = sx; Z1 = sz; X2 = dx; Z2 = dz;
            end else begin
                dx = fm(fm(X1, X1), fm(X1, X1)) ^ fm(b, fm(fm(Z1, Z1), fm(Z1, Z1)));
                dz = fm(fm(X1, X1), fm(Z1, Z1));
                X2 = sx; Z2 = sz; X1 = dx; Z1 = dz;
            end
        end
        return {X1, Z1, X2, Z2};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // mode: 0 plain, 1 start pulse while busy, 2 fault injection
    task automatic run(input logic [6:0] k, input logic [6:0] x, input logic [6:0] b,
                       input int mode, output int lat);
        int n;
        @(negedge clk);
        scalar = k; bx = x; cb = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        scalar = ~k; bx = ~x; cb = ~b;   // R1: later input changes must not matter
        n = 0;
        while (!done && n < 2000) begin
            @(posedge clk);
            n++;
            if (mode == 2 && n == 100) force dut.u_lane_b.prod0 = '1;
            if (mode == 2 && n == 160) release dut.u_lane_b.prod0;
            @(negedge clk);
            if (mode == 1 && n == 20) begin
                scalar = 7'h7F; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        lat = n;
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        finish_run();
    end

    initial begin
        int lat, exp_lat;
        logic [27:0] exp_v;
        logic [6:0] k;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check({x1, z1, x2, z2, done, fault} == '0, "R10 reset outputs",
              32'({x1, z1, x2, z2, done, fault}), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: scalars 0 and 1 give the start values
        for (int s = 0; s < 2; s++) begin
            run(7'(s), 7'h15, 7'h2A, 0, lat);
            exp_v = {7'h15, 7'h01, fm(fm(7'h15, 7'h15), fm(7'h15, 7'h15)) ^ 7'h2A, fm(7'h15, 7'h15)};
            check({x1, z1, x2, z2} == exp_v, "R4 start values", 32'({x1, z1, x2, z2}), 32'(exp_v));
            check(lat == 2 * (M + 2) + 1, "R5 latency small scalar", 32'(lat), 32'(2 * (M + 2) + 1));
        end

        // R3/R5/R8/R1: exhaustive sweep over the scalar, two curve settings
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 2; s < 128; s += (pass == 0) ? 1 : 5) begin
                logic [6:0] xv, bv;
                xv = (pass == 0) ? 7'h05 : 7'h3B;
                bv = (pass == 0) ? 7'h01 : 7'h66;
                k  = 7'(s);
                run(k, xv, bv, 0, lat);
                exp_v   = ref_ladder(k, xv, bv);
                exp_lat = (2 + 6 * top_bit(k)) * (M + 2) + 1;
                check({x1, z1, x2, z2} == exp_v, "R3 ladder result", 32'({x1, z1, x2, z2}), 32'(exp_v));
                check(lat == exp_lat, "R5 latency", 32'(lat), 32'(exp_lat));
                check(fault == 1'b0, "R8 no fault", 32'(fault), 32'h0);
            end
        end

        // R2: done is a single-cycle pulse
        @(negedge clk);
        check(done == 1'b0, "R2 done one cycle", 32'(done), 32'h0);

        // R9: outputs hold while idle
        exp_v = {x1, z1, x2, z2};
        repeat (15) @(negedge clk);
        check({x1, z1, x2, z2} == exp_v, "R9 outputs hold", 32'({x1, z1, x2, z2}), 32'(exp_v));

        // R6: start during a run is ignored
        run(7'h4B, 7'h29, 7'h13, 1, lat);
        exp_v = ref_ladder(7'h4B, 7'h29, 7'h13);
        check({x1, z1, x2, z2} == exp_v, "R6 busy start result", 32'({x1, z1, x2, z2}), 32'(exp_v));
        check(lat == (2 + 36) * (M + 2) + 1, "R6 busy start latency", 32'(lat), 32'((2 + 36) * (M + 2) + 1));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R6 no second completion", 32'(done), 32'h0);

        // R7: fault in one lane
        run(7'h6D, 7'h05, 7'h01, 2, lat);
        check(done == 1'b1 && fault == 1'b1, "R7 fault raised", 32'({done, fault}), 32'h3);
        check({x1, z1, x2, z2} == '0, "R7 outputs zeroed", 32'({x1, z1, x2, z2}), 32'h0);
        repeat (5) @(negedge clk);
        check(fault == 1'b1, "R9 fault holds", 32'(fault), 32'h1);

        // R8: a clean run clears the flag
        run(7'h33, 7'h05, 7'h01, 0, lat);
        exp_v = ref_ladder(7'h33, 7'h05, 7'h01);
        check(fault == 1'b0, "R8 fault cleared", 32'(fault), 32'h0);
        check({x1, z1, x2, z2} == exp_v, "R8 result after fault", 32'({x1, z1, x2, z2}), 32'(exp_v));

        finish_run();
    end
endmodule